// File: doc/BRIEF.md
# Sector Lock Command Sequencer

This block sits on the write and read path of a memory device. It watches bus writes for a three-step command that locks or unlocks sectors. A write-enable pin that stands for the elevated-voltage reset condition must be high for the command to be accepted. Once the command is complete, the block runs a timed operation. Locking takes much less time than unlocking.

Locking sets the flag of one sector. Unlocking clears the flags of every sector. The block reports busy while the timer runs. A read strobe returns the flag of the sector whose number sits in the top address bits. Software uses this read to verify the result after the operation ends. Operation lengths are given in microseconds and converted to clock cycles from a clock-frequency parameter when the design is elaborated.

Top module: `sector_lock_seq`

## Requirements
- R1: An operation starts only when three writes arrive in a row with data 0x60, 0x60 and then 0x40. Each of the three writes must have address bit 1 high, address bit 0 low and `hv_en` high. `busy` goes high in the cycle after the third write.
- R2: If address bit 6 is low on the third write, the operation is a lock. At its end, only the flag of the sector in `wr_addr[ADDR_W-1 -: SECT_W]` of that write is set. All other flags keep their values.
- R3: If address bit 6 is high on the third write, the operation is an unlock. At its end, every sector flag is cleared.
- R4: `busy` stays high for exactly `PROT_CYC` cycles for a lock, where `PROT_CYC` = `CLK_HZ`·`PROT_US`/10^6.
- R5: `busy` stays high for exactly `UNPROT_CYC` cycles for an unlock, where `UNPROT_CYC` = `CLK_HZ`·`UNPROT_US`/10^6.
- R6: Any write made while `hv_en` is low and no operation is running returns the sequence to its start. It does not begin an operation.
- R7: A write with wrong data or wrong address bits 1 and 0 at any step returns the sequence to its start. No sector flag changes except at the end of an operation.
- R8: While `busy` is high, writes are ignored. The running operation keeps its kind, sector and length.
- R9: A read strobe gives `rd_valid` high in the next cycle. Alongside it, `rd_status` carries the flag of the sector in `rd_addr[ADDR_W-1 -: SECT_W]`, or 0 if the read was made while `busy` was high.
- R10: After reset, `busy` and `rd_valid` are low and all sector flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_en | input | 1 | High when the elevated-voltage reset condition is present |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; the top SECT_W bits give the sector |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Verify read strobe |
| rd_addr | input | ADDR_W | Read address; the top SECT_W bits give the sector |
| busy | output | 1 | Timed operation in progress |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_status | output | 1 | Lock flag of the sector that was read |

## Verification
The command is applied in several forms, and each form separates one decode path from the others:
- A clean lock and a clean unlock check the split on bit 6, and that the operation lengths differ.
- A broken data byte and a wrong low address bit check that the sequence falls back to its start.
- A full sequence sent with `hv_en` low checks the voltage gate.
- A second full sequence sent during a running lock checks that a busy operation cannot be retargeted or lengthened.

After each operation, every sector is read back. This shows that a lock touched only one flag and that an unlock cleared all of them. Reads made while `busy` is high confirm that the status is masked during an operation.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM1 = 2'd1,
        ST_ARM2 = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    typedef enum logic {
        OP_LOCK   = 1'b0,
        OP_UNLOCK = 1'b1
    } op_kind_e;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'h40;
    localparam int         SEL_BIT     = 6;
    localparam int         KEY_HI_BIT  = 1;
    localparam int         KEY_LO_BIT  = 0;

    typedef struct packed {
        logic     is_setup;
        logic     is_confirm;
        logic     key_ok;
        op_kind_e kind;
    } wr_decode_t;

    function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
        logic [63:0] prod;
        prod = 64'(hz) * 64'(us) / 64'd1_000_000;
        if (prod == 64'd0) prod = 64'd1;
        return prod[31:0];
    endfunction

endpackage

// File: rtl/spp_cmd_fsm.sv
module spp_cmd_fsm
    import spp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hv_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              done,
    output logic              start,
    output op_kind_e          op_kind,
    output logic [SECT_W-1:0] op_sector,
    output logic              busy
);

    seq_state_e state_q, state_d;
    wr_decode_t dec;

    always_comb begin
        dec.is_setup   = (wr_data == CMD_SETUP);
        dec.is_confirm = (wr_data == CMD_CONFIRM);
        dec.key_ok     = wr_addr[KEY_HI_BIT] & ~wr_addr[KEY_LO_BIT];
        dec.kind       = wr_addr[SEL_BIT] ? OP_UNLOCK : OP_LOCK;
    end

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (done) state_d = ST_IDLE;
            end
            default: begin
                if (wr_en) begin
                    if (!hv_en || !dec.key_ok) begin
                        state_d = ST_IDLE;
                    end else begin
                        unique case (state_q)
                            ST_IDLE: state_d = dec.is_setup ? ST_ARM1 : ST_IDLE;
                            ST_ARM1: state_d = dec.is_setup ? ST_ARM2 : ST_IDLE;
                            ST_ARM2: begin
                                if (dec.is_confirm) begin
                                    state_d = ST_RUN;
                                    start   = 1'b1;
                                end else begin
                                    state_d = ST_IDLE;
                                end
                            end
                            default: state_d = ST_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_kind   <= OP_LOCK;
            op_sector <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                op_kind   <= dec.kind;
                op_sector <= wr_addr[ADDR_W-1 -: SECT_W];
            end
        end
    end

    assign busy = (state_q == ST_RUN);

endmodule

// File: rtl/spp_op_timer.sv
module spp_op_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/spp_lock_array.sv
module spp_lock_array
    import spp_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    parameter int SECT_W      = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   done,
    input  op_kind_e               op_kind,
    input  logic [SECT_W-1:0]      op_sector,
    input  logic                   busy,
    input  logic                   rd_en,
    input  logic [SECT_W-1:0]      rd_sector,
    output logic                   rd_valid,
    output logic                   rd_status,
    output logic [NUM_SECTORS-1:0] lock_bits
);

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sect
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_bits[s] <= 1'b0;
            end else if (done) begin
                if (op_kind == OP_UNLOCK)
                    lock_bits[s] <= 1'b0;
                else if (op_sector == SECT_W'(s))
                    lock_bits[s] <= 1'b1;
            end
        end
    end

    logic sel_bit;
    always_comb begin
        sel_bit = 1'b0;
        for (int s = 0; s < NUM_SECTORS; s++)
            if (rd_sector == SECT_W'(s)) sel_bit = lock_bits[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_status <= 1'b0;
        end else begin
            rd_valid  <= rd_en;
            rd_status <= rd_en & ~busy & sel_bit;
        end
    end

endmodule

// File: rtl/sector_lock_seq.sv
module sector_lock_seq
    import spp_pkg::*;
#(
    parameter int          NUM_SECTORS = 8,
    parameter int          ADDR_W      = 16,
    parameter int unsigned CLK_HZ      = 200_000_000,
    parameter int unsigned PROT_US     = 150,
    parameter int unsigned UNPROT_US   = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hv_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic              rd_status
);

    localparam int          SECT_W     = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
    localparam int unsigned PROT_CYC   = us_to_cycles(CLK_HZ, PROT_US);
    localparam int unsigned UNPROT_CYC = us_to_cycles(CLK_HZ, UNPROT_US);
    localparam int unsigned MAX_CYC    = (PROT_CYC > UNPROT_CYC) ? PROT_CYC : UNPROT_CYC;
    localparam int          CNT_W      = $clog2(MAX_CYC + 1);

    logic                   start, done;
    op_kind_e               op_kind;
    logic [SECT_W-1:0]      op_sector;
    logic [CNT_W-1:0]       load_val;
    logic [NUM_SECTORS-1:0] lock_bits;

    spp_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
        .clk(clk), .rst(rst), .hv_en(hv_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .start(start), .op_kind(op_kind), .op_sector(op_sector), .busy(busy)
    );

    assign load_val = wr_addr[SEL_BIT] ? CNT_W'(UNPROT_CYC) : CNT_W'(PROT_CYC);

    spp_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .load_val(load_val), .done(done)
    );

    spp_lock_array #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst(rst), .done(done), .op_kind(op_kind),
        .op_sector(op_sector), .busy(busy), .rd_en(rd_en),
        .rd_sector(rd_addr[ADDR_W-1 -: SECT_W]),
        .rd_valid(rd_valid), .rd_status(rd_status), .lock_bits(lock_bits)
    );

endmodule

// File: rtl/spp_checker.sv
module spp_checker
    import spp_pkg::*;
#(
    parameter int          NUM_SECTORS = 8,
    parameter int          SECT_W      = 3,
    parameter int unsigned PROT_CYC    = 1,
    parameter int unsigned UNPROT_CYC  = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   hv_en,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic                   busy,
    input logic                   rd_valid,
    input logic                   rd_status,
    input op_kind_e               op_kind,
    input logic [SECT_W-1:0]      op_sector,
    input logic [NUM_SECTORS-1:0] lock_bits
);

    int unsigned run_len;
    logic        busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
            busy_q  <= 1'b0;
        end else begin
            busy_q  <= busy;
            run_len <= busy ? run_len + 1 : 0;
        end
    end

    assert_start_gate_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(hv_en && wr_en));

    assert_lock_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && op_kind == OP_LOCK) |-> lock_bits[op_sector]);

    assert_unlock_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && op_kind == OP_UNLOCK) |-> (lock_bits == '0));

    assert_lock_len_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && busy_q && op_kind == OP_LOCK) |-> (run_len == PROT_CYC));

    assert_unlock_len_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && busy_q && op_kind == OP_UNLOCK) |-> (run_len == UNPROT_CYC));

    assert_hv_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hv_en && !busy) |=> !busy);

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> (lock_bits == $past(lock_bits)));

    assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> ($stable(op_sector) && $stable(op_kind)));

    assert_rd_valid_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_rd_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> !rd_status);

endmodule

bind sector_lock_seq spp_checker #(
    .NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W),
    .PROT_CYC(PROT_CYC), .UNPROT_CYC(UNPROT_CYC)
) u_spp_checker (
    .clk(clk), .rst(rst), .hv_en(hv_en), .wr_en(wr_en), .rd_en(rd_en),
    .busy(busy), .rd_valid(rd_valid), .rd_status(rd_status),
    .op_kind(op_kind), .op_sector(op_sector), .lock_bits(lock_bits)
);

// File: tb/sector_lock_seq_bench.sv
module sector_lock_seq_bench;

    localparam int NSEC   = 8;
    localparam int AW     = 16;
    localparam int SW     = 3;
    localparam int HZ     = 1_000_000;
    localparam int P_CYC  = 150;
    localparam int U_CYC  = 1500;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hv_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy, rd_valid, rd_status;

    sector_lock_seq #(.NUM_SECTORS(NSEC), .ADDR_W(AW), .CLK_HZ(HZ),
                      .PROT_US(150), .UNPROT_US(1500)) u_sector_lock_seq (
        .clk(clk), .rst(rst), .hv_en(hv_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .busy(busy), .rd_valid(rd_valid), .rd_status(rd_status)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model
    int    m_stage, m_remain, m_sec;
    bit    m_unlock;
    bit    m_flags[NSEC];
    bit    m_rv, m_rs;
    int    vectors = 0, fails = 0, cycles = 0;
    string cur_req = "R10";

    function automatic logic [AW-1:0] mk(input int sec, input bit a6, input bit a1, input bit a0);
        logic [AW-1:0] a;
        a = '0;
        a[AW-1 -: SW] = SW'(sec);
        a[6] = a6; a[1] = a1; a[0] = a0;
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0; m_remain = 0; m_rv = 0; m_rs = 0; m_unlock = 0; m_sec = 0;
            foreach (m_flags[i]) m_flags[i] = 0;
        end else begin
            m_rv = rd_en;
            m_rs = rd_en && (m_remain == 0) && m_flags[int'(rd_addr[AW-1 -: SW])];
            if (m_remain > 0) begin
                m_remain--;
                if (m_remain == 0) begin
                    if (m_unlock) foreach (m_flags[i]) m_flags[i] = 0;
                    else m_flags[m_sec] = 1;
                end
            end else if (wr_en) begin
                if (!hv_en || !(wr_addr[1] && !wr_addr[0])) m_stage = 0;
                else if (m_stage < 2) m_stage = (wr_data == 8'h60) ? m_stage + 1 : 0;
                else begin
                    m_stage = 0;
                    if (wr_data == 8'h40) begin
                        m_unlock = wr_addr[6];
                        m_sec    = int'(wr_addr[AW-1 -: SW]);
                        m_remain = m_unlock ? U_CYC : P_CYC;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        vectors++;
        if (busy !== (m_remain > 0) || rd_valid !== m_rv || rd_status !== m_rs) begin
            fails++;
            $display("FAIL %s cycle %0d: busy/rd_valid/rd_status actual %b%b%b expected %b%b%b",
                     cur_req, cycles, busy, rd_valid, rd_status, m_remain > 0, m_rv, m_rs);
        end
        if (cycles > 100_000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic do_write(input int sec, input bit a6, input bit a1, input bit a0, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = mk(sec, a6, a1, a0); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_cmd(input int sec, input bit unlock);
        do_write(sec, 0, 1, 0, 8'h60);
        do_write(sec, 0, 1, 0, 8'h60);
        do_write(sec, unlock, 1, 0, 8'h40);
    endtask

    task automatic read_all();
        for (int s = 0; s < NSEC; s++) begin
            @(negedge clk);
            rd_en = 1'b1; rd_addr = mk(s, 0, 0, 0);
        end
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_remain > 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cur_req = "R10";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_all();

        cur_req = "R2";            // lock sector 3, R1 and R4 covered by busy compare
        hv_en = 1'b1;
        do_cmd(3, 0);
        cur_req = "R4";
        wait_idle();
        cur_req = "R2";
        read_all();
        do_cmd(5, 0);
        wait_idle();
        read_all();

        cur_req = "R7";            // broken data, then wrong low address bit
        do_write(6, 0, 1, 0, 8'h60);
        do_write(6, 0, 1, 0, 8'h55);
        do_write(6, 0, 1, 0, 8'h40);
        do_write(6, 0, 1, 0, 8'h60);
        do_write(6, 0, 1, 1, 8'h60);
        do_write(6, 0, 1, 0, 8'h40);
        repeat (5) @(negedge clk);
        read_all();

        cur_req = "R6";            // full sequence without the voltage gate
        hv_en = 1'b0;
        do_cmd(0, 1);
        repeat (5) @(negedge clk);
        read_all();
        hv_en = 1'b1;

        cur_req = "R8";            // retarget attempt during a running lock
        do_cmd(1, 0);
        repeat (10) @(negedge clk);
        do_cmd(2, 1);
        cur_req = "R9";
        @(negedge clk); rd_en = 1'b1; rd_addr = mk(3, 0, 0, 0);
        @(negedge clk); rd_en = 1'b0;
        cur_req = "R8";
        wait_idle();
        read_all();

        cur_req = "R5";            // unlock all
        do_cmd(4, 1);
        wait_idle();
        cur_req = "R3";
        read_all();

        cur_req = "R1";
        do_cmd(7, 0);
        wait_idle();
        read_all();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule